// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synchronous single-port memory with a registered read path. It serves a 32-bit data path split into four byte lanes. Accesses start from one of two address strobes: one driven by a processor and one driven by a cache controller. The strobes differ in priority and in when a write can land. Three chip selects qualify each new access. After an access starts, an advance input steps a two-bit wrapping burst counter, and the counter order is either linear or interleaved.

On every clock edge the controller classifies the cycle as deselect, begin, continue or suspend, for reads and for writes alike. Byte-masked writes go into the array. Read data is staged through an output register. The block drives an output-enable for an external bidirectional data pad. That enable is gated by an asynchronous output-enable input and masked by the rules for writes, deselects and the first cycle of a read. A sleep input freezes the controller after a two-edge entry delay and keeps the array contents.

Top module: `burst_sram_ctl`

## Requirements
- R1: A new access begins at a clock edge only when a strobe is recognised and sel1_n=0, sel2=1 and sel3_n=0. A recognised strobe with any of those selects inactive deselects the block, and nothing is written.
- R2: When proc_stb_n and ctl_stb_n are both low, only the processor strobe counts. proc_stb_n is ignored entirely while sel1_n is high.
- R3: A processor-strobe access always begins as a read, and the write inputs and adv_n are ignored on that edge. A write to the captured address happens at the following edge, when no strobe is present and the write inputs request it.
- R4: A controller-strobe access, with the processor strobe not recognised, writes dq_in at the captured address on that same edge when the write inputs request it.
- R5: gw_n=0 writes all four lanes whatever bwe_n and lane_n are. Otherwise, with bwe_n=0, lane g (dq bits 8g+7..8g) is written only when lane_n[g]=0. Lanes that are not written keep their contents. With gw_n=1 and bwe_n=1 the access is a read.
- R6: Read data for the address used at edge k is on dq_out after edge k+1, and dq_oe is high only while oe_n is low (combinational). Back-to-back reads started on consecutive edges deliver data on consecutive cycles.
- R7: In the cycle after a read begins from the deselected state, dq_oe stays low even with oe_n low.
- R8: After an edge that performs a write, or an edge that deselects the block, dq_oe is low.
- R9: With no strobe recognised while the block is selected, adv_n=0 steps the burst counter and adv_n=1 reuses the current address, for reads and writes alike. The two low address bits are start+count (mod 4) when lin_order=1, and start XOR count when lin_order=0.
- R10: Sleep entry takes two edges. An access at the first edge that samples sleep=1 is still performed, and later edges are ignored until recovery. dq_oe stays low while asleep, and the array contents are kept.
- R11: After sleep falls, strobes and selects are still ignored at the first two edges that sample sleep=0. The block then comes up deselected and accepts a new access at the third edge.
- R12: A synchronous active-high rst deselects the block and drops dq_oe. No read or write is pending after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Word address, captured on a begin edge |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip select 1, active low, also gates proc_stb_n |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, active high |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| dq_in | input | 8*LANES | Write data from the pad |
| dq_out | output | 8*LANES | Registered read data to the pad |
| dq_oe | output | 1 | Pad driver enable |

## Verification
The bench uses the defaults AW=6 and LANES=4. That gives a 64-word array in which every burst start offset, both wrap orders and all four byte lanes can be reached in a few cycles. A 64-word array also lets each directed scenario use its own address range, so a stray write from a wrong strobe decision shows up as a corrupted neighbour on read-back. The four-lane width matches the byte-select and global-write override encodings named in R5.

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr,
  input  logic               proc_stb_n,
  input  logic               ctl_stb_n,
  input  logic               sel1_n,
  input  logic               sel2,
  input  logic               sel3_n,
  input  logic               adv_n,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [LANES-1:0]   lane_n,
  input  logic               oe_n,
  input  logic               sleep,
  input  logic               lin_order,
  input  logic [8*LANES-1:0] dq_in,
  output logic [8*LANES-1:0] dq_out,
  output logic               dq_oe
);

  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [1:0]       zz_q;
  logic             act_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic [AW-1:0]    rd_addr_q;
  logic             rd_pend_q;
  logic             out_rd_q;
  logic [DW-1:0]    out_q;
  logic [LANES-1:0] lanes;
  logic [AW-1:0]    acc_addr;

  wire blocked   = |zz_q;
  wire sel_all   = !sel1_n && sel2 && !sel3_n;
  wire p_hit     = !proc_stb_n && !sel1_n;
  wire c_hit     = !ctl_stb_n && !p_hit;
  wire any_hit   = p_hit || c_hit;
  wire begin_any = !blocked && any_hit && sel_all;
  wire desel     = !blocked && any_hit && !sel_all;
  wire cont      = !blocked && !any_hit && act_q;

  assign lanes = !gw_n ? '1 : (!bwe_n ? ~lane_n : '0);
  wire wr_req  = |lanes;

  wire [1:0] cnt_nx  = (cont && !adv_n) ? cnt_q + 2'd1 : cnt_q;
  wire [1:0] lo_bits = lin_order ? base_q[1:0] + cnt_nx : base_q[1:0] ^ cnt_nx;
  assign acc_addr    = begin_any ? addr : {base_q[AW-1:2], lo_bits};

  wire do_wr = (begin_any && c_hit && wr_req) || (cont && wr_req);
  wire do_rd = (begin_any && !(c_hit && wr_req)) || (cont && !wr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      zz_q      <= '0;
      act_q     <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      rd_addr_q <= '0;
      rd_pend_q <= 1'b0;
      out_rd_q  <= 1'b0;
      out_q     <= '0;
    end else begin
      zz_q <= {zz_q[0], sleep};
      if (blocked || desel) act_q <= 1'b0;
      else if (begin_any)   act_q <= 1'b1;
      if (begin_any) begin
        base_q <= addr;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
      rd_addr_q <= acc_addr;
      rd_pend_q <= do_rd;
      out_rd_q  <= rd_pend_q && !desel && !do_wr && !blocked;
      out_q     <= mem[rd_addr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && do_wr) begin
      for (int g = 0; g < LANES; g++) begin
        if (lanes[g]) mem[acc_addr][8*g +: 8] <= dq_in[8*g +: 8];
      end
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = out_rd_q && !oe_n;

endmodule

// File: rtl/burst_sram_ctl_chk.sv
module burst_sram_ctl_chk (
  input logic clk,
  input logic rst,
  input logic oe_n,
  input logic dq_oe,
  input logic asleep,
  input logic desel,
  input logic begin_any,
  input logic act_q
);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst) dq_oe |-> !oe_n);

  // R12
  reset_release_chk: assert property (@(posedge clk) rst |=> !dq_oe);

  // R8
  desel_release_chk: assert property (@(posedge clk) disable iff (rst) desel |=> !dq_oe);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst) asleep |-> !dq_oe);

  // R7
  first_read_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (begin_any && !act_q) |=> !dq_oe);

endmodule

bind burst_sram_ctl burst_sram_ctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .oe_n      (oe_n),
  .dq_oe     (dq_oe),
  .asleep    (zz_q[1]),
  .desel     (desel),
  .begin_any (begin_any),
  .act_q     (act_q)
);

// File: tb/sim_burst_sram_ctl.sv
module sim_burst_sram_ctl;
  localparam int AW = 6;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic proc_stb_n = 1'b1, ctl_stb_n = 1'b1;
  logic sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1;
  logic [LANES-1:0] lane_n = '1;
  logic oe_n = 1'b0, sleep = 1'b0, lin_order = 1'b1;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic dq_oe;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_sram_ctl #(.AW(AW), .LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n), .sleep(sleep), .lin_order(lin_order),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_oe(input string req, input logic exp);
    chk(req, {31'b0, dq_oe}, {31'b0, exp});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    proc_stb_n = 1; ctl_stb_n = 1; sel1_n = 0; sel2 = 1; sel3_n = 0;
    adv_n = 1; gw_n = 1; bwe_n = 1; lane_n = '1; oe_n = 0;
  endtask

  task automatic desel();
    idle(); ctl_stb_n = 0; sel2 = 0; step(); idle();
  endtask

  task automatic cwr(input int a, input logic [31:0] d);
    idle(); ctl_stb_n = 0; addr = 6'(a); dq_in = d; gw_n = 0; step(); idle();
  endtask

  task automatic rd1(input string req, input int a, input logic [31:0] e);
    desel();
    proc_stb_n = 0; addr = 6'(a); step(); idle();
    chk_oe("R7 first read cycle masked", 1'b0);
    step();
    chk_oe(req, 1'b1);
    chk(req, dq_out, e);
    desel();
    chk_oe("R8 deselect releases bus", 1'b0);
  endtask

  task automatic t_reset();
    chk_oe("R12 reset state", 1'b0);
    cwr(1, 32'h5555_AAAA);
    desel(); proc_stb_n = 0; addr = 6'd1; step(); idle(); step();
    chk_oe("R12 driving before reset", 1'b1);
    rst = 1; step(); rst = 0;
    chk_oe("R12 reset drops enable", 1'b0);
    step();
    chk_oe("R12 deselected after reset", 1'b0);
  endtask

  task automatic t_ctrl_write();
    cwr(3, 32'h1111_2222);
    rd1("R4 controller write same edge", 3, 32'h1111_2222);
    idle(); ctl_stb_n = 0; addr = 6'd3; dq_in = 32'hFFFF_0000; gw_n = 0; sel3_n = 1; step(); idle();
    rd1("R1 sel3_n high blocks write", 3, 32'h1111_2222);
    idle(); ctl_stb_n = 0; addr = 6'd3; dq_in = 32'hFFFF_0001; gw_n = 0; sel1_n = 1; step(); idle();
    rd1("R1 sel1_n high blocks write", 3, 32'h1111_2222);
  endtask

  task automatic t_bytes();
    cwr(4, 32'hA5A5_A5A5);
    idle(); ctl_stb_n = 0; addr = 6'd4; dq_in = 32'h1122_3344; bwe_n = 0; lane_n = 4'b1010; step(); idle();
    rd1("R5 lanes 0 and 2 only", 4, 32'hA522_A544);
    idle(); ctl_stb_n = 0; addr = 6'd4; dq_in = 32'hDEAD_BEEF; gw_n = 0; bwe_n = 1; lane_n = '1; step(); idle();
    rd1("R5 global write overrides", 4, 32'hDEAD_BEEF);
    idle(); ctl_stb_n = 0; addr = 6'd4; dq_in = 32'h0; lane_n = 4'b0000; step(); idle();
    rd1("R5 no enable means read", 4, 32'hDEAD_BEEF);
  endtask

  task automatic t_proc_write();
    cwr(10, 32'h0A0A_0A0A);
    desel(); proc_stb_n = 0; addr = 6'd10; dq_in = 32'h0000_0BAD; gw_n = 0; step();
    desel();
    rd1("R3 first edge never writes", 10, 32'h0A0A_0A0A);
    desel(); proc_stb_n = 0; addr = 6'd12; step(); idle();
    gw_n = 0; dq_in = 32'h1212_1212; step();
    chk_oe("R8 write edge releases bus", 1'b0);
    desel();
    rd1("R3 write on second edge", 12, 32'h1212_1212);
  endtask

  task automatic t_priority();
    logic [31:0] v [4];
    cwr(11, 32'h0B0B_0B0B);
    desel(); proc_stb_n = 0; ctl_stb_n = 0; addr = 6'd11; dq_in = 32'h0; gw_n = 0; step();
    desel();
    rd1("R2 both strobes act as read", 11, 32'h0B0B_0B0B);
    for (int i = 0; i < 4; i++) begin
      v[i] = 32'hC0DE_0000 + 32'(i);
      cwr(16 + i, v[i]);
    end
    lin_order = 1;
    desel(); proc_stb_n = 0; addr = 6'd16; step(); idle();
    proc_stb_n = 0; sel1_n = 1; adv_n = 0; step(); idle();
    chk_oe("R2 strobe ignored with sel1_n high", 1'b1);
    chk("R2 strobe ignored with sel1_n high", dq_out, v[0]);
    step();
    chk("R2 burst continued", dq_out, v[1]);
    desel();
  endtask

  task automatic t_burst(input logic lin, input int start);
    logic [31:0] got [5];
    desel(); lin_order = lin; proc_stb_n = 0; addr = 6'(start); step(); idle();
    for (int i = 0; i < 5; i++) begin
      adv_n = (i < 3) ? 1'b0 : 1'b1;
      step();
      got[i] = dq_out;
    end
    idle();
    for (int i = 0; i < 5; i++) begin
      int c = (i < 4) ? i : 3;
      int lo = lin ? ((start + c) % 4) : ((start % 4) ^ c);
      chk(lin ? "R9 linear burst" : "R9 interleaved burst", got[i], 32'hC0DE_0000 + 32'(lo));
    end
    desel();
  endtask

  task automatic t_burst_write();
    lin_order = 1;
    cwr(22, 32'h0);
    cwr(20, 32'hAAAA_0000);
    ctl_stb_n = 1; gw_n = 0; adv_n = 0; dq_in = 32'hAAAA_0001; step();
    gw_n = 0; adv_n = 0; dq_in = 32'hAAAA_0002; step();
    gw_n = 0; adv_n = 1; dq_in = 32'hAAAA_0003; step();
    desel();
    rd1("R9 burst write advance", 21, 32'hAAAA_0001);
    rd1("R9 burst write suspend", 22, 32'hAAAA_0003);
  endtask

  task automatic t_oe();
    desel(); proc_stb_n = 0; addr = 6'd3; step(); idle(); step();
    oe_n = 1; #1;
    chk_oe("R6 oe_n high releases bus", 1'b0);
    oe_n = 0; #1;
    chk_oe("R6 oe_n low drives bus", 1'b1);
    desel();
    proc_stb_n = 0; addr = 6'd16; step();
    proc_stb_n = 0; addr = 6'd18; step(); idle();
    chk("R6 back-to-back first", dq_out, 32'hC0DE_0000);
    step();
    chk("R6 back-to-back second", dq_out, 32'hC0DE_0002);
    chk_oe("R6 back-to-back driven", 1'b1);
    desel();
  endtask

  task automatic t_sleep();
    cwr(30, 32'h3030_3030);
    cwr(31, 32'h3131_3131);
    cwr(34, 32'h3434_3434);
    desel();
    sleep = 1; ctl_stb_n = 0; addr = 6'd33; dq_in = 32'h3333_3333; gw_n = 0; step();
    ctl_stb_n = 0; addr = 6'd34; dq_in = 32'hBAD0_0034; gw_n = 0; step();
    ctl_stb_n = 0; addr = 6'd30; dq_in = 32'hBAD0_0030; step();
    idle(); proc_stb_n = 0; addr = 6'd30; step(); idle(); step();
    chk_oe("R10 bus quiet while asleep", 1'b0);
    sleep = 0; ctl_stb_n = 0; addr = 6'd31; dq_in = 32'hBAD0_0031; gw_n = 0; step();
    ctl_stb_n = 0; addr = 6'd31; dq_in = 32'hBAD0_0031; gw_n = 0; step();
    chk_oe("R11 bus quiet in recovery", 1'b0);
    cwr(32, 32'h3232_3232);
    desel();
    rd1("R10 contents kept", 30, 32'h3030_3030);
    rd1("R10 entry edge still served", 33, 32'h3333_3333);
    rd1("R10 second edge ignored", 34, 32'h3434_3434);
    rd1("R11 recovery edges ignored", 31, 32'h3131_3131);
    rd1("R11 third edge accepted", 32, 32'h3232_3232);
  endtask

  initial begin
    idle();
    step(); step(); step();
    rst = 0;
    t_reset();
    t_ctrl_write();
    t_bytes();
    t_proc_write();
    t_priority();
    t_burst(1'b1, 17);
    t_burst(1'b0, 17);
    t_burst(1'b0, 18);
    t_burst_write();
    t_oe();
    t_sleep();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule